// File: doc/BRIEF.md
# Free-Running 8-Bit Timer Counter with Overflow Flag

This block is an 8-bit up-counter that runs without stopping. It advances once per tick from a selectable prescaler. Three of the tick rates are the CPU clock divided by 2, 4 or 8. The fourth rate comes from a separate oscillator clock divided by 8000. That oscillator tick is carried into the CPU clock domain as a one-cycle enable.

Software reaches the block through a small register port. One control register selects the tick rate and enables the interrupt. A status register shows the overflow flag. The count can be read from two addresses that return the same value. A read of the main address takes part in clearing the flag. A read of the alias address never affects the flag.

Any write to either counter address restarts the count at FCh. FCh is also the value after reset. When the count wraps from FFh to 00h, the overflow flag is set. The interrupt line is the flag gated by the enable bit.

The flag is cleared by a two-step sequence that a state machine tracks. The states are:
- `OVF_CLEAR`: the flag is low.
- `OVF_PENDING`: the flag is set and the status register has not yet been read.
- `OVF_ARMED`: the flag is set and the status register has been read.

The transitions are:
- wrap: `OVF_CLEAR` to `OVF_PENDING`.
- status read: `OVF_PENDING` to `OVF_ARMED`.
- main counter read: `OVF_ARMED` to `OVF_CLEAR`.
- re-wrap: `OVF_ARMED` back to `OVF_PENDING`.

Top module: `tmr8_core`

## Requirements
- R1: The count rises by exactly one on each prescaler tick and holds between ticks. After FFh it wraps to 00h, not to FCh.
- R2: Reset sets the following state: count FCh, flag clear, control register 00h (tick rate CPU/2, interrupt disabled) and `irq` low.
- R3: A write of any data to address 2 (main count) or address 3 (alias count) gives a count of FCh in the next cycle. The write also restarts the CPU prescaler phase and leaves the flag unchanged.
- R4: Reads are combinational on `bus_rdata`, and the address map is fixed:
  - address 0: control register
  - address 1: status register, with the flag in bit 7 and all other bits 0
  - address 2: main count
  - address 3: alias count

  Addresses 2 and 3 always return the same value.
- R5: A read strobe at address 3 never clears the flag. A read of address 2 clears nothing unless a status read came first.
- R6: Control bits [1:0] select the tick rate: 00 gives CPU/2, 01 gives CPU/4 and 10 gives CPU/8. At a rate of N, the first increment after a restart lands N cycles after the write edge. A free-running count repeats every 256·N cycles.
- R7: The flag (status bit 7) is set in the same cycle as the FFh-to-00h wrap.
- R8: Control bits [1:0] = 11 select the oscillator clock divided by 8000. Each such tick arrives as a single-cycle enable in the CPU domain.
- R9: The flag clears after two reads in order: a status read (read strobe at address 1) while the flag is set, and then a later read strobe at address 2. If a wrap occurs between those two reads, a new status read is needed before a main read can clear the flag.
- R10: `irq` equals the flag ANDed with control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_clk | input | 1 | Oscillator clock for the divide-by-8000 tick |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe; drives the side effects of a read |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench checks the count at exact cycle offsets from a restart, both one cycle before and exactly at each tick boundary, for all three CPU rates. This catches a design with off-by-one prescaler phasing or a prescaler that is not restarted by a write. It also checks that the count wraps to 00h and not FCh, and that the flag rises at the wrap edge. The remaining tests cover the flag-clear sequence:
- an alias read between the status read and the main read;
- a main read with no status read before it;
- a write to the count while the flag is set;
- a wrap that lands between the two reads.

A design that clears on any counter read, or that clears on the main read alone, leaves the flag low where the bench expects it high.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int ADDR_W = 2;
    localparam int SEL_W  = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_MAIN  = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_ALIAS = 2'd3;

    localparam logic [SEL_W-1:0] SEL_OSC = 2'b11;

    typedef enum logic [1:0] {
        OVF_CLEAR   = 2'd0,
        OVF_PENDING = 2'd1,
        OVF_ARMED   = 2'd2
    } ovf_state_e;

endpackage

// File: rtl/tmr8_presc.sv
module tmr8_presc #(
    parameter int NTAP  = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] tap_i,
    output logic             tick_o
);
    localparam int NSEL = 1 << SEL_W;

    logic [NTAP-1:0] cnt_q;
    logic [NSEL-1:0] tap_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    // Tap i ticks once every 2^(i+1) cycles; unused select codes never tick.
    for (genvar i = 0; i < NSEL; i++) begin : g_tap
        if (i < NTAP) begin : g_live
            assign tap_tick[i] = &cnt_q[i:0];
        end else begin : g_dead
            assign tap_tick[i] = 1'b0;
        end
    end

    assign tick_o = tap_tick[tap_i];

    // R6: CPU-derived ticks are never back to back
    assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/tmr8_osc_tick.sv
module tmr8_osc_tick #(
    parameter int DIV = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_clk,
    output logic pulse_o
);
    localparam int DW = $clog2(DIV);
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic          orst1_q, orst2_q;
    logic [DW-1:0] div_q;
    logic          tgl_q;
    logic [2:0]    sync_q;

    // Reset release synchronised to the oscillator clock
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) {orst2_q, orst1_q} <= 2'b00;
        else        {orst2_q, orst1_q} <= {orst1_q, 1'b1};
    end

    // Divider toggles a level once per DIV oscillator cycles
    always_ff @(posedge osc_clk or negedge orst2_q) begin
        if (!orst2_q) begin
            div_q <= '0;
            tgl_q <= 1'b0;
        end else if (div_q == LAST) begin
            div_q <= '0;
            tgl_q <= ~tgl_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Two-flop synchroniser plus edge detect gives one CPU-cycle pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tgl_q};
    end

    assign pulse_o = sync_q[1] ^ sync_q[2];

    // R8: the oscillator tick lasts exactly one CPU cycle
    assert_osc_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/tmr8_ovf_fsm.sv
module tmr8_ovf_fsm
    import tmr8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic stat_rd_i,
    input  logic main_rd_i,
    input  logic alias_rd_i,
    output logic flag_o
);
    ovf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OVF_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_CLEAR:   if (wrap_i) state_d = OVF_PENDING;
            OVF_PENDING: if (stat_rd_i) state_d = OVF_ARMED;
            OVF_ARMED: begin
                if (wrap_i)         state_d = OVF_PENDING;
                else if (main_rd_i) state_d = OVF_CLEAR;
            end
            default:                state_d = OVF_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q != OVF_CLEAR);
    end

    // R7: a wrap leaves the flag set
    assert_wrap_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> flag_o);

    // R5: an alias read never clears the flag
    assert_alias_keeps_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && alias_rd_i) |=> flag_o);

    // R9: the flag cannot drop without a main read
    assert_clear_needs_main_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !main_rd_i) |=> flag_o);

endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
#(
    parameter int          CNT_W   = 8,
    parameter logic [7:0]  RELOAD  = 8'hFC,
    parameter int          NTAP    = 3,
    parameter int          OSC_DIV = 8000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         osc_clk,
    input  logic [1:0]   bus_addr,
    input  logic         bus_rd,
    input  logic         bus_wr,
    input  logic [7:0]   bus_wdata,
    output logic [7:0]   bus_rdata,
    output logic         irq
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RELOAD);

    logic [CNT_W-1:0] count_q;
    logic [SEL_W-1:0] sel_q;
    logic             ie_q;
    logic             restart, cpu_tick, osc_tick, tick, wrap, flag;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata[6:2];

    assign restart = bus_wr && (bus_addr == ADR_MAIN || bus_addr == ADR_ALIAS);

    // Control register: tick rate and interrupt enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            ie_q  <= 1'b0;
        end else if (bus_wr && bus_addr == ADR_CTRL) begin
            sel_q <= bus_wdata[SEL_W-1:0];
            ie_q  <= bus_wdata[7];
        end
    end

    tmr8_presc #(.NTAP(NTAP), .SEL_W(SEL_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (restart),
        .tap_i  (sel_q),
        .tick_o (cpu_tick)
    );

    tmr8_osc_tick #(.DIV(OSC_DIV)) u_osc (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_clk (osc_clk),
        .pulse_o (osc_tick)
    );

    assign tick = (sel_q == SEL_OSC) ? osc_tick : cpu_tick;
    assign wrap = tick && !restart && (count_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count_q <= CNT_INIT;
        else if (restart) count_q <= CNT_INIT;
        else if (tick)    count_q <= count_q + 1'b1;
    end

    tmr8_ovf_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap_i     (wrap),
        .stat_rd_i  (bus_rd && bus_addr == ADR_STAT),
        .main_rd_i  (bus_rd && bus_addr == ADR_MAIN),
        .alias_rd_i (bus_rd && bus_addr == ADR_ALIAS),
        .flag_o     (flag)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CTRL:  bus_rdata = {ie_q, 5'b0, sel_q};
            ADR_STAT:  bus_rdata = {flag, 7'b0};
            ADR_MAIN:  bus_rdata = 8'(count_q);
            ADR_ALIAS: bus_rdata = 8'(count_q);
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = flag && ie_q;

    // R3: any counter write restarts at the reload value
    assert_restart_fc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count_q == CNT_INIT));

    // R1: without a tick or a restart the count holds
    assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(count_q));

    // R1: a tick advances the count by one, wrapping to zero
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: tb/tb_tmr8_core.sv
`timescale 1ns/1ps
module tb_tmr8_core;

    logic       clk = 1'b0;
    logic       osc_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2   clk = ~clk;
    always #1.5 osc_clk = ~osc_clk;

    tmr8_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_clk   (osc_clk),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // {sel[1:0], edges after restart[7:0], expected count[7:0], expected flag}
    localparam int NV = 14;
    localparam logic [18:0] VEC [NV] = '{
        {2'd0, 8'd0,  8'hFC, 1'b0},
        {2'd0, 8'd1,  8'hFC, 1'b0},
        {2'd0, 8'd2,  8'hFD, 1'b0},
        {2'd0, 8'd7,  8'hFF, 1'b0},
        {2'd0, 8'd8,  8'h00, 1'b1},
        {2'd0, 8'd10, 8'h01, 1'b1},
        {2'd1, 8'd3,  8'hFC, 1'b0},
        {2'd1, 8'd4,  8'hFD, 1'b0},
        {2'd1, 8'd15, 8'hFF, 1'b0},
        {2'd1, 8'd16, 8'h00, 1'b1},
        {2'd2, 8'd7,  8'hFC, 1'b0},
        {2'd2, 8'd8,  8'hFD, 1'b0},
        {2'd2, 8'd31, 8'hFF, 1'b0},
        {2'd2, 8'd32, 8'h00, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic strobe_rd(input logic [1:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic clear_flag();
        strobe_rd(2'd1);
        strobe_rd(2'd2);
    endtask

    // Restart at /2 and wait for the wrap so the flag is set
    task automatic make_flag();
        write(2'd0, 8'h00);
        write(2'd2, 8'h00);
        repeat (8) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #700000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, m, al;
        repeat (3) @(negedge clk);
        // R2: reset state
        peek(2'd2, d); chk("R2 count", d, 8'hFC);
        peek(2'd1, d); chk("R2 status", d, 8'h00);
        peek(2'd0, d); chk("R2 control", d, 8'h00);
        chk("R2 irq", {7'b0, irq}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 R4 R6 R7: table of rates and offsets
        for (int v = 0; v < NV; v++) begin
            clear_flag();
            write(2'd0, {6'b0, VEC[v][18:17]});
            write(2'd2, 8'h5A);
            repeat (VEC[v][16:9]) @(posedge clk);
            @(negedge clk);
            peek(2'd2, m);  chk("R6 main count", m, VEC[v][8:1]);
            peek(2'd3, al); chk("R4 alias equals main", al, m);
            peek(2'd1, d);  chk("R7 flag", d, {VEC[v][0], 7'b0});
        end

        // R6: period of 512 cycles at CPU/2
        clear_flag();
        write(2'd0, 8'h00);
        write(2'd3, 8'hFF);
        repeat (512) @(posedge clk);
        @(negedge clk);
        peek(2'd2, d); chk("R6 period 512", d, 8'hFC);
        peek(2'd1, d); chk("R7 flag after period", d, 8'h80);

        // R5: alias read after status read keeps the flag
        clear_flag();
        make_flag();
        strobe_rd(2'd1);
        strobe_rd(2'd3);
        peek(2'd1, d); chk("R5 alias read keeps flag", d, 8'h80);
        // R9: main read after the status read clears it
        strobe_rd(2'd2);
        peek(2'd1, d); chk("R9 status then main clears", d, 8'h00);

        // R5: main read alone does not clear
        make_flag();
        strobe_rd(2'd2);
        peek(2'd1, d); chk("R5 main read alone keeps flag", d, 8'h80);

        // R3: a counter write leaves the flag alone and restarts at FCh
        write(2'd3, 8'h55);
        peek(2'd1, d); chk("R3 write keeps flag", d, 8'h80);
        peek(2'd2, d); chk("R3 alias write restarts", d, 8'hFC);

        // R10: interrupt gating
        chk("R10 irq masked", {7'b0, irq}, 8'h00);
        write(2'd0, 8'h80);
        #0.5;
        chk("R10 irq enabled", {7'b0, irq}, 8'h01);
        peek(2'd0, d); chk("R4 control readback", d, 8'h80);
        clear_flag();
        #0.5;
        chk("R10 irq after clear", {7'b0, irq}, 8'h00);

        // R9: wrap between status read and main read re-arms
        make_flag();
        strobe_rd(2'd1);
        repeat (520) @(posedge clk);
        @(negedge clk);
        strobe_rd(2'd2);
        peek(2'd1, d); chk("R9 re-wrap needs new status read", d, 8'h80);
        clear_flag();
        peek(2'd1, d); chk("R9 second sequence clears", d, 8'h00);

        // R8: oscillator divided by 8000
        write(2'd0, 8'h03);
        write(2'd2, 8'h00);
        #108000;
        @(negedge clk);
        peek(2'd2, d);
        chk("R8 osc count near wrap", {7'b0, (d == 8'h00 || d == 8'h01)}, 8'h01);
        peek(2'd1, d); chk("R8 osc wrap sets flag", d, 8'h80);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule